// File: doc/BRIEF.md
# Residue Basis Extension Unit

This unit takes an integer held in residue form over a fixed set of small coprime moduli, called the source moduli, and produces its residue modulo each of a list of further target moduli, one target at a time. The integer is assumed to be below the product Q of the source moduli. The unit rebuilds the integer as a weighted sum of its residues with wide constant weights. That sum can exceed Q by a whole multiple, so the unit works out the multiple k as the floor of the sum divided by Q. At the same time it forms a narrow weighted sum using the weights already reduced modulo the current target. The target residue is then the narrow sum minus k times Q, both taken modulo the target, and the result is brought into range.

A caller presents all source residues and pulses `start` while `ready` is high. The unit then steps through every target in index order. Each target result comes out with a one-cycle `resValid` strobe and the index of that target. `ready` stays low until the last target has been produced, and a `start` pulse seen in that time is ignored. All weights, reciprocals and reduced constants are derived at elaboration from the moduli parameters.

Top module: `rbx_top`

## Requirements
- R1: After reset `ready` is 1, `resValid` is 0 and `resOut` is 0.
- R2: For an accepted integer x < Q, the result for target index j equals x mod dj, where dj is the j-th target modulus (`DST_MODS` bits [j*RES_W +: RES_W]), and it always lies in 0..dj-1.
- R3: Target results come in ascending index order 0..NUM_DST-1. Target j's strobe is seen in the cycle after the (4+4j)-th rising edge that follows the edge at which `start` was accepted, and `resTgt` carries j.
- R4: A `start` pulse while `ready` is low is ignored: the results of the conversion in progress, and the timing of them, do not change.
- R5: `ready` drops after the accepting edge and comes back after the edge that produces the last target's result. A `start` at that same edge is not accepted.
- R6: `resValid` is high for exactly one cycle per target result.
- R7: The extreme inputs x = 0 and x = Q-1 give exact results for every target.
- R8: The computed multiple k satisfies k*Q <= S < (k+1)*Q, where S is the wide weighted sum. The reciprocal estimate is never left one short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion when `ready` is high |
| residIn | input | NUM_SRC*RES_W | Source residues, residue i in bits [i*RES_W +: RES_W] |
| ready | output | 1 | Idle, a new conversion may start |
| resOut | output | RES_W | Residue for the current target |
| resTgt | output | TW | Index of the target that `resOut` belongs to |
| resValid | output | 1 | One-cycle strobe marking `resOut` |

## Verification
The range and exactness assertions take for granted that each source residue is below its own modulus and that the residues describe one integer below Q. Without that, the weighted sum can reach a k wider than its register. The bench never drives residues directly. It draws an integer below Q, including 0 and Q-1, and takes its residues, so the inputs are always consistent. It also sends extra `start` pulses only while a conversion is in flight, so the rule that such pulses are ignored gets exercised against the unchanged results.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

  // One-hot step strobes from control to datapath
  typedef struct packed {
    logic load;
    logic sum;
    logic est;
    logic fix;
    logic out;
  } rbxStep_t;

endpackage

// File: rtl/rbx_ctrl.sv
module rbx_ctrl
  import rbx_pkg::*;
#(
  parameter int NUM_DST = 2,
  parameter int TW      = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output rbxStep_t      stb,
  output logic [TW-1:0] tgtIdx,
  output logic          ready
);

  typedef enum logic [2:0] {IDLE, SUM, EST, FIX, OUT} phase_t;

  phase_t phase;
  logic   lastTgt;

  assign lastTgt = (tgtIdx == TW'(NUM_DST - 1));
  assign ready   = (phase == IDLE);

  always_comb begin
    stb      = '0;
    stb.load = (phase == IDLE) && start;
    stb.sum  = (phase == SUM);
    stb.est  = (phase == EST);
    stb.fix  = (phase == FIX);
    stb.out  = (phase == OUT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= IDLE;
      tgtIdx <= '0;
    end else begin
      unique case (phase)
        IDLE: if (start) begin
          phase  <= SUM;
          tgtIdx <= '0;
        end
        SUM: phase <= EST;
        EST: phase <= FIX;
        FIX: phase <= OUT;
        OUT: begin
          if (lastTgt) phase <= IDLE;
          else begin
            phase  <= SUM;
            tgtIdx <= tgtIdx + 1'b1;
          end
        end
        default: phase <= IDLE;
      endcase
    end
  end

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R3

  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && start && phase != OUT) |=> !ready); // R4

  AST_TGT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (stb.out && !lastTgt) |=> (tgtIdx == $past(tgtIdx) + 1'b1)); // R3

endmodule

// File: rtl/rbx_datapath.sv
module rbx_datapath
  import rbx_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int NUM_DST = 2,
  parameter int RES_W   = 16,
  parameter int TW      = 1,
  parameter logic [NUM_SRC*RES_W-1:0] SRC_MODS = '1,
  parameter logic [NUM_DST*RES_W-1:0] DST_MODS = '1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rbxStep_t                 stb,
  input  logic [TW-1:0]            tgtIdx,
  input  logic [NUM_SRC*RES_W-1:0] residIn,
  output logic [RES_W-1:0]         resOut,
  output logic [TW-1:0]            resTgt,
  output logic                     resValid
);

  localparam int IW    = $clog2(NUM_SRC + 1);
  localparam int QW    = NUM_SRC * RES_W;
  localparam int KW    = RES_W + IW;
  localparam int LSW   = QW + KW;
  localparam int SHIFT = LSW;
  localparam int RW    = LSW - QW + NUM_SRC + 1;
  localparam int SSW   = 2 * RES_W + IW;
  localparam int PW    = 2 * RES_W;

  function automatic logic [255:0] srcMod(input int i);
    return 256'(SRC_MODS[i*RES_W +: RES_W]);
  endfunction

  function automatic logic [255:0] dstMod(input int j);
    return 256'(DST_MODS[j*RES_W +: RES_W]);
  endfunction

  function automatic logic [255:0] qProd();
    logic [255:0] p = 256'd1;
    for (int i = 0; i < NUM_SRC; i++) p = p * srcMod(i);
    return p;
  endfunction

  function automatic longint invMod(input longint a, input longint m);
    longint t = 0, nt = 1, r = m, nr = a % m, qq, tmp;
    while (nr != 0) begin
      qq = r / nr;
      tmp = t - qq * nt; t = nt; nt = tmp;
      tmp = r - qq * nr; r = nr; nr = tmp;
    end
    if (t < 0) t = t + m;
    return t;
  endfunction

  localparam logic [255:0] Q_BIG     = qProd();
  localparam logic [QW-1:0] Q_VAL    = QW'(Q_BIG);
  localparam logic [255:0] RECIP_BIG = (256'd1 << SHIFT) / Q_BIG;
  localparam logic [RW-1:0] RECIP    = RW'(RECIP_BIG);

  function automatic logic [255:0] weight(input int i);
    logic [255:0] co = Q_BIG / srcMod(i);
    longint inv = invMod(longint'(co % srcMod(i)), longint'(srcMod(i)));
    return co * 256'(inv);
  endfunction

  // Constant tables
  logic [QW-1:0]    wTab   [NUM_SRC];
  logic [RES_W-1:0] wModTab[NUM_SRC][NUM_DST];
  logic [RES_W-1:0] dTab   [NUM_DST];

  // Pipeline state
  logic [RES_W-1:0] residReg [NUM_SRC];
  logic [LSW-1:0]   sumReg, longAcc;
  logic [SSW-1:0]   shortReg, shortAcc;
  logic [KW-1:0]    kEstReg, kReg;
  logic [RES_W-1:0] shortModReg;
  logic [RES_W-1:0] shortModArr[NUM_DST];
  logic [RES_W-1:0] corrArr    [NUM_DST];
  logic [LSW+RW-1:0] scaled;
  logic [LSW-1:0]   remain;
  logic [RES_W-1:0] corr, modSel, resNext;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [255:0] W_I = weight(i);
    assign wTab[i] = QW'(W_I);
    for (genvar j = 0; j < NUM_DST; j++) begin : g_dst
      localparam logic [255:0] WM_IJ = W_I % dstMod(j);
      assign wModTab[i][j] = RES_W'(WM_IJ);
    end
  end

  for (genvar j = 0; j < NUM_DST; j++) begin : g_tgt
    localparam logic [255:0] D_J  = dstMod(j);
    localparam logic [255:0] QM_J = Q_BIG % D_J;
    logic [RES_W-1:0] kMod;
    assign dTab[j]        = RES_W'(D_J);
    assign shortModArr[j] = RES_W'(shortReg % SSW'(D_J));
    assign kMod           = RES_W'(kReg % KW'(D_J));
    assign corrArr[j]     = RES_W'((PW'(kMod) * PW'(QM_J)) % PW'(D_J));
  end

  // Long path and short path side by side
  always_comb begin
    longAcc  = '0;
    shortAcc = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      longAcc  = longAcc + LSW'(residReg[i]) * LSW'(wTab[i]);
      shortAcc = shortAcc + SSW'(residReg[i]) * SSW'(wModTab[i][tgtIdx]);
    end
  end

  assign scaled  = (LSW+RW)'(sumReg) * (LSW+RW)'(RECIP);
  assign remain  = sumReg - LSW'(kEstReg) * LSW'(Q_VAL);
  assign corr    = corrArr[tgtIdx];
  assign modSel  = dTab[tgtIdx];
  assign resNext = (shortModReg >= corr) ? shortModReg - corr
                                         : shortModReg + (modSel - corr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) residReg[i] <= '0;
      sumReg      <= '0;
      shortReg    <= '0;
      kEstReg     <= '0;
      kReg        <= '0;
      shortModReg <= '0;
      resOut      <= '0;
      resTgt      <= '0;
      resValid    <= 1'b0;
    end else begin
      resValid <= stb.out;
      if (stb.load)
        for (int i = 0; i < NUM_SRC; i++) residReg[i] <= residIn[i*RES_W +: RES_W];
      if (stb.sum) begin
        sumReg   <= longAcc;
        shortReg <= shortAcc;
      end
      if (stb.est) begin
        kEstReg     <= KW'(scaled >> SHIFT);
        shortModReg <= shortModArr[tgtIdx];
      end
      if (stb.fix)
        kReg <= (remain >= LSW'(Q_VAL)) ? kEstReg + 1'b1 : kEstReg;
      if (stb.out) begin
        resOut <= resNext;
        resTgt <= tgtIdx;
      end
    end
  end

  AST_K_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    stb.out |-> ((LSW+1)'(kReg) * (LSW+1)'(Q_VAL) <= (LSW+1)'(sumReg) &&
                 (LSW+1)'(sumReg) < ((LSW+1)'(kReg) + 1) * (LSW+1)'(Q_VAL))); // R8

  AST_RES_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resOut < dTab[resTgt])); // R2

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid); // R6

endmodule

// File: rtl/rbx_top.sv
module rbx_top
  import rbx_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int NUM_DST = 2,
  parameter int RES_W   = 16,
  parameter logic [NUM_SRC*RES_W-1:0] SRC_MODS = {16'd65497, 16'd65519, 16'd65521},
  parameter logic [NUM_DST*RES_W-1:0] DST_MODS = {16'd65449, 16'd65479},
  localparam int TW = (NUM_DST > 1) ? $clog2(NUM_DST) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [NUM_SRC*RES_W-1:0] residIn,
  output logic                     ready,
  output logic [RES_W-1:0]         resOut,
  output logic [TW-1:0]            resTgt,
  output logic                     resValid
);

  rbxStep_t      stb;
  logic [TW-1:0] tgtIdx;

  rbx_ctrl #(.NUM_DST(NUM_DST), .TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .stb(stb), .tgtIdx(tgtIdx), .ready(ready)
  );

  rbx_datapath #(
    .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .RES_W(RES_W), .TW(TW),
    .SRC_MODS(SRC_MODS), .DST_MODS(DST_MODS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tgtIdx(tgtIdx), .residIn(residIn),
    .resOut(resOut), .resTgt(resTgt), .resValid(resValid)
  );

endmodule

// File: tb/tb_rbx_top.sv
module tb_rbx_top;

  localparam int NS = 3;
  localparam int ND = 2;
  localparam int RW = 16;
  localparam logic [NS*RW-1:0] SMODS = {16'd65497, 16'd65519, 16'd65521};
  localparam logic [ND*RW-1:0] DMODS = {16'd65449, 16'd65479};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NS*RW-1:0] residIn = '0;
  logic ready, resValid;
  logic [RW-1:0] resOut;
  logic [0:0] resTgt;

  rbx_top #(.NUM_SRC(NS), .NUM_DST(ND), .RES_W(RW), .SRC_MODS(SMODS), .DST_MODS(DMODS)) dut (
    .clk(clk), .rstN(rstN), .start(start), .residIn(residIn),
    .ready(ready), .resOut(resOut), .resTgt(resTgt), .resValid(resValid)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  longint unsigned qAll;
  longint unsigned curX;

  // Reference model state
  bit mActive = 0;
  int mCnt = 0;
  longint unsigned mX = 0;
  bit mIgnored = 0;
  bit expV = 0;
  int expJ = 0;

  function automatic longint unsigned sMod(int i);
    return longint'(SMODS[i*RW +: RW]);
  endfunction
  function automatic longint unsigned dMod(int j);
    return longint'(DMODS[j*RW +: RW]);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mCnt = 0; expV = 0; mIgnored = 0;
    end else begin
      expV = 0;
      if (mActive) begin
        if (start) mIgnored = 1;
        mCnt++;
        if (mCnt % 4 == 0) begin
          expV = 1;
          expJ = mCnt / 4 - 1;
        end
        if (mCnt == 4 * ND) mActive = 0;
      end else if (start) begin
        mActive = 1; mCnt = 0; mX = curX; mIgnored = 0;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(ready == !mActive, "R5", longint'(ready), longint'(!mActive));
      check(resValid == expV, "R6", longint'(resValid), longint'(expV));
      if (expV && resValid) begin
        check(int'(resTgt) == expJ, "R3", longint'(resTgt), longint'(expJ));
        if (mX == 0 || mX == qAll - 1)
          check(longint'(resOut) == longint'(mX % dMod(expJ)), "R7",
                longint'(resOut), longint'(mX % dMod(expJ)));
        else if (mIgnored)
          check(longint'(resOut) == longint'(mX % dMod(expJ)), "R4",
                longint'(resOut), longint'(mX % dMod(expJ)));
        else
          check(longint'(resOut) == longint'(mX % dMod(expJ)), "R2",
                longint'(resOut), longint'(mX % dMod(expJ)));
      end
    end
  end

  task automatic setX(input longint unsigned x);
    curX = x;
    for (int i = 0; i < NS; i++) residIn[i*RW +: RW] = RW'(x % sMod(i));
  endtask

  task automatic runOne(input longint unsigned x, input bit poke);
    @(negedge clk);
    setX(x);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      setX((x + 12345) % qAll);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (mActive) @(negedge clk);
  endtask

  initial begin
    qAll = 1;
    for (int i = 0; i < NS; i++) qAll = qAll * sMod(i);
    curX = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ready == 1'b1, "R1", longint'(ready), 1);
    check(resValid == 1'b0, "R1", longint'(resValid), 0);
    check(resOut == '0, "R1", longint'(resOut), 0);
    rstN = 1'b1;
    runOne(0, 0);
    runOne(qAll - 1, 0);
    runOne(1, 0);
    runOne(qAll / 2, 1);
    runOne(qAll - 2, 1);
    for (int n = 0; n < 40; n++) begin
      longint unsigned r = {32'($urandom), 32'($urandom)};
      runOne(r % qAll, (n % 5) == 0);
    end
    // R5: start held high across the last result edge, then re-accepted
    @(negedge clk);
    setX(777);
    start = 1'b1;
    repeat (4 * ND + 3) @(negedge clk);
    start = 1'b0;
    while (mActive) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule